// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block walks the upper two levels of a three-level radix page table for one translation request at a time. It takes a virtual page number, a table page number and a translation mode. For each level it forms the entry address and presents it to an external permission checker, which answers in the same cycle. If the checker allows the access, the block reads the entry from memory and decodes it. A walk ends in one of three ways: a large-page leaf goes back to the requester, a non-leaf entry at the second level is handed to a separate last-level walker, or a fault is reported.

When the mode calls for guest translation, the block sends guest page numbers to a second-stage translation port. It does this before each table read and before returning a final leaf. Every entry that comes back from memory is also sent to a page cache as a one-cycle refill record. Every request and result port uses a valid/ready handshake.

Top module: `pt2_walker`

## Requirements
- R1: After reset `req_ready` is high and all output valids are low. A request is accepted only while idle. From acceptance until the walk's final handshake, `req_ready` stays low.
- R2: The mode is taken from `req_mode`: 00 is no translation stage 2, 01 is stage 1 only, 10 is stage 2 only, 11 is all stages. In modes 00 and 01 the first entry address is {`req_ppn`, vpn[26:18], 000}. The permission check sees the same address that is then used for the memory read.
- R3: If the permission checker flags the address, that entry is not read. The response then has `resp_af`=1 and `resp_level` set to the level being walked.
- R4: A valid non-leaf entry at level 2 starts a read at level 1. Its address is {entry PPN, vpn[17:9], 000}. A valid non-leaf entry at level 1 is handed off through `ll_*` with the vpn, the entry PPN (bits 53:10) and the mode.
- R5: An entry with R (bit 1) or X (bit 3) set is a leaf. It is returned with `resp_level` 2 or 1, the raw entry on `resp_pte`, and its PPN on `resp_ppn`.
- R6: An entry with V (bit 0) clear, or with W (bit 2) set and R clear, ends the walk with `resp_pf`=1 at that level.
- R7: Stage-2-only mode issues exactly one second-stage request for `req_ppn` and no memory read. It returns the translated page number with `resp_level`=0.
- R8: In all-stage mode, every table page number is sent to the second-stage port before its table is read, starting with `req_ppn`. The read then uses the translated page number. A leaf's PPN is also translated, and `resp_ppn` carries the translated value.
- R9: An all-stage request with `req_s1_hit`=1 sends only `req_ppn` for second-stage translation. It then returns the result with `resp_level`=0 and reads no memory.
- R10: A second-stage response with `s2_resp_fault`=1 ends the walk with `resp_gpf`=1 and no further memory read.
- R11: The cycle after each memory response handshake, `refill_valid` pulses for one cycle. The record carries the vpn, the level just read, the entry, and `refill_s1`: 1 for modes 01 and 11, 0 for mode 00.
- R12: Each output valid, once raised, stays high with a stable payload until its ready is seen.
- R13: An entry with any of bits 63:54 set counts as a page fault (`resp_pf`=1) when the reserved-bit option is on (the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | New walk request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_mode | input | 2 | Translation mode |
| req_s1_hit | input | 1 | All-stage request whose first stage already hit |
| req_vpn | input | 27 | Virtual page number |
| req_ppn | input | 44 | Root table page, guest page to translate, or hit page |
| pmp_req | output | 1 | Address presented for permission check |
| pmp_addr | output | 56 | Entry address under check |
| pmp_fault | input | 1 | Same-cycle access fault from checker |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 56 | Entry physical address |
| mem_resp_valid | input | 1 | Entry data returned |
| mem_resp_ready | output | 1 | Walker waiting for entry |
| mem_resp_data | input | 64 | Entry contents |
| s2_req_valid | output | 1 | Second-stage translation request |
| s2_req_ready | input | 1 | Second-stage port accepts |
| s2_req_gppn | output | 44 | Guest page number to translate |
| s2_resp_valid | input | 1 | Second-stage result |
| s2_resp_ready | output | 1 | Walker waiting for second-stage result |
| s2_resp_ppn | input | 44 | Translated page number |
| s2_resp_fault | input | 1 | Guest page fault |
| refill_valid | output | 1 | Page cache refill pulse |
| refill_vpn | output | 27 | Vpn of the refilled entry |
| refill_level | output | 2 | Level of the refilled entry |
| refill_s1 | output | 1 | Entry belongs to a first-stage-of-two table |
| refill_pte | output | 64 | Refilled entry |
| resp_valid | output | 1 | Result to requester |
| resp_ready | input | 1 | Requester accepts result |
| resp_level | output | 2 | Level of leaf or fault, 0 when no table was walked |
| resp_ppn | output | 44 | Final page number |
| resp_pte | output | 64 | Last entry read |
| resp_pf | output | 1 | Page fault |
| resp_af | output | 1 | Access fault |
| resp_gpf | output | 1 | Guest page fault |
| ll_valid | output | 1 | Handoff to last-level walker |
| ll_ready | input | 1 | Last-level walker accepts |
| ll_vpn | output | 27 | Vpn for last-level walk |
| ll_ppn | output | 44 | Last-level table page |
| ll_mode | output | 2 | Mode of handed-off request |

## Verification
The walk is driven for every mode and every outcome that mode allows. The outcomes are a leaf at level 2 or 1, a handoff, a page fault from a clear V bit, from write-without-read or from reserved bits, an access fault at either level, and a guest fault. Each outcome is run with two vpn/table-page pairs: one with all vpn bits set and table pages near the top of the range, one with mixed bits. This separates the wrong slice or level from the right one. Every memory read is held off for one cycle, so a payload that drifts before its handshake shows up. The translated and untranslated page numbers are kept apart by a fixed XOR in the stand-in second stage, so a read of an untranslated table in all-stage mode gives a wrong address.

// File: rtl/pt2_pkg.sv
package pt2_pkg;

   localparam int unsigned PTE_W   = 64;
   localparam int unsigned PPN_LSB = 10;
   localparam int unsigned FLAG_W  = 4;
   localparam int unsigned BIT_V   = 0;
   localparam int unsigned BIT_R   = 1;
   localparam int unsigned BIT_W   = 2;
   localparam int unsigned BIT_X   = 3;

   typedef enum logic [1:0] {
      XL_NONE = 2'b00,
      XL_S1   = 2'b01,
      XL_S2   = 2'b10,
      XL_ALL  = 2'b11
   } xlate_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_S2_REQ,
      ST_S2_WAIT,
      ST_PMP,
      ST_MEM_REQ,
      ST_MEM_WAIT,
      ST_CHECK,
      ST_RESP,
      ST_HANDOFF
   } walk_state_e;

endpackage

// File: rtl/pt2_pte_decode.sv
module pt2_pte_decode
   import pt2_pkg::*;
#(
   parameter int unsigned PPN_W      = 44,
   parameter bit          STRICT_RSV = 1'b1
) (
   input  logic [PTE_W-1:PPN_LSB] hi,
   input  logic [FLAG_W-1:0]      flags,
   output logic                   leaf,
   output logic                   fault,
   output logic [PPN_W-1:0]       ppn
);

   localparam int unsigned RSV_LSB = PPN_LSB + PPN_W;

   logic rsv_nz;

   if (RSV_LSB > PTE_W) begin : g_bad_width
      $error("pt2_pte_decode: PPN_W does not fit in an entry");
   end

   if (STRICT_RSV && (RSV_LSB < PTE_W)) begin : g_rsv_chk
      assign rsv_nz = |hi[PTE_W-1:RSV_LSB];
   end else begin : g_rsv_off
      assign rsv_nz = 1'b0;
   end

   assign ppn   = hi[RSV_LSB-1:PPN_LSB];
   assign leaf  = flags[BIT_R] | flags[BIT_X];
   assign fault = !flags[BIT_V] | (flags[BIT_W] & !flags[BIT_R]) | rsv_nz;

endmodule

// File: rtl/pt2_addr_gen.sv
module pt2_addr_gen #(
   parameter int unsigned PPN_W      = 44,
   parameter int unsigned VPN_SLICE  = 9,
   parameter int unsigned LEVELS     = 3,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned LVL_W      = 2,
   localparam int unsigned VPN_W     = VPN_SLICE * LEVELS,
   localparam int unsigned PA_W      = PPN_W + PAGE_SHIFT,
   localparam int unsigned ENT_SHIFT = PAGE_SHIFT - VPN_SLICE
) (
   input  logic [PPN_W-1:0] table_ppn,
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   output logic [PA_W-1:0]  addr
);

   logic [VPN_SLICE-1:0] slice_arr [LEVELS];
   logic [VPN_SLICE-1:0] slice_sel;

   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slice_arr[g] = vpn[g*VPN_SLICE +: VPN_SLICE];
   end

   always_comb begin
      slice_sel = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (lvl == LVL_W'(i)) slice_sel = slice_arr[i];
      end
   end

   assign addr = {table_ppn, slice_sel, {ENT_SHIFT{1'b0}}};

endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
   import pt2_pkg::*;
#(
   parameter int unsigned PPN_W      = 44,
   parameter int unsigned VPN_SLICE  = 9,
   parameter int unsigned LEVELS     = 3,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter bit          STRICT_RSV = 1'b1,
   localparam int unsigned VPN_W     = VPN_SLICE * LEVELS,
   localparam int unsigned PA_W      = PPN_W + PAGE_SHIFT,
   localparam int unsigned LVL_W     = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_mode,
   input  logic             req_s1_hit,
   input  logic [VPN_W-1:0] req_vpn,
   input  logic [PPN_W-1:0] req_ppn,
   output logic             pmp_req,
   output logic [PA_W-1:0]  pmp_addr,
   input  logic             pmp_fault,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_resp_valid,
   output logic             mem_resp_ready,
   input  logic [63:0]      mem_resp_data,
   output logic             s2_req_valid,
   input  logic             s2_req_ready,
   output logic [PPN_W-1:0] s2_req_gppn,
   input  logic             s2_resp_valid,
   output logic             s2_resp_ready,
   input  logic [PPN_W-1:0] s2_resp_ppn,
   input  logic             s2_resp_fault,
   output logic             refill_valid,
   output logic [VPN_W-1:0] refill_vpn,
   output logic [LVL_W-1:0] refill_level,
   output logic             refill_s1,
   output logic [63:0]      refill_pte,
   output logic             resp_valid,
   input  logic             resp_ready,
   output logic [LVL_W-1:0] resp_level,
   output logic [PPN_W-1:0] resp_ppn,
   output logic [63:0]      resp_pte,
   output logic             resp_pf,
   output logic             resp_af,
   output logic             resp_gpf,
   output logic             ll_valid,
   input  logic             ll_ready,
   output logic [VPN_W-1:0] ll_vpn,
   output logic [PPN_W-1:0] ll_ppn,
   output logic [1:0]       ll_mode
);

   localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(LEVELS - 1);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(1);

   if (LEVELS < 2) begin : g_bad_levels
      $error("pt2_walker: at least two levels are needed");
   end
   if (PAGE_SHIFT != VPN_SLICE + 3) begin : g_bad_shift
      $error("pt2_walker: a table page must hold 2**VPN_SLICE eight-byte entries");
   end
   if (PPN_LSB + PPN_W > PTE_W) begin : g_bad_ppn
      $error("pt2_walker: PPN_W too wide for the entry format");
   end

   walk_state_e      state_q;
   xlate_mode_e      mode_q;
   logic [VPN_W-1:0] vpn_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PPN_W-1:0] tbl_ppn_q;
   logic [PPN_W-1:0] gppn_q;
   logic [PPN_W-1:0] res_ppn_q;
   logic [63:0]      pte_q;
   logic             final_s2_q;
   logic             af_q;
   logic             pf_q;
   logic             gpf_q;
   logic             refill_q;

   logic             dec_leaf;
   logic             dec_fault;
   logic [PPN_W-1:0] dec_ppn;
   logic [PA_W-1:0]  ent_addr;
   xlate_mode_e      req_mode_e;

   assign req_mode_e = xlate_mode_e'(req_mode);

   pt2_addr_gen #(
      .PPN_W      (PPN_W),
      .VPN_SLICE  (VPN_SLICE),
      .LEVELS     (LEVELS),
      .PAGE_SHIFT (PAGE_SHIFT),
      .LVL_W      (LVL_W)
   ) u_addr (
      .table_ppn (tbl_ppn_q),
      .vpn       (vpn_q),
      .lvl       (lvl_q),
      .addr      (ent_addr)
   );

   pt2_pte_decode #(
      .PPN_W      (PPN_W),
      .STRICT_RSV (STRICT_RSV)
   ) u_dec (
      .hi    (pte_q[PTE_W-1:PPN_LSB]),
      .flags (pte_q[FLAG_W-1:0]),
      .leaf  (dec_leaf),
      .fault (dec_fault),
      .ppn   (dec_ppn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= XL_NONE;
         vpn_q      <= '0;
         lvl_q      <= '0;
         tbl_ppn_q  <= '0;
         gppn_q     <= '0;
         res_ppn_q  <= '0;
         pte_q      <= '0;
         final_s2_q <= 1'b0;
         af_q       <= 1'b0;
         pf_q       <= 1'b0;
         gpf_q      <= 1'b0;
         refill_q   <= 1'b0;
      end else begin
         refill_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q     <= req_vpn;
                  mode_q    <= req_mode_e;
                  af_q      <= 1'b0;
                  pf_q      <= 1'b0;
                  gpf_q     <= 1'b0;
                  pte_q     <= '0;
                  res_ppn_q <= '0;
                  unique case (req_mode_e)
                     XL_NONE, XL_S1: begin
                        lvl_q      <= TOP_LVL;
                        tbl_ppn_q  <= req_ppn;
                        final_s2_q <= 1'b0;
                        state_q    <= ST_PMP;
                     end
                     XL_S2: begin
                        lvl_q      <= '0;
                        gppn_q     <= req_ppn;
                        final_s2_q <= 1'b1;
                        state_q    <= ST_S2_REQ;
                     end
                     default: begin
                        lvl_q      <= req_s1_hit ? '0 : TOP_LVL;
                        gppn_q     <= req_ppn;
                        final_s2_q <= req_s1_hit;
                        state_q    <= ST_S2_REQ;
                     end
                  endcase
               end
            end
            ST_S2_REQ: begin
               if (s2_req_ready) state_q <= ST_S2_WAIT;
            end
            ST_S2_WAIT: begin
               if (s2_resp_valid) begin
                  if (s2_resp_fault) begin
                     gpf_q   <= 1'b1;
                     state_q <= ST_RESP;
                  end else if (final_s2_q) begin
                     res_ppn_q <= s2_resp_ppn;
                     state_q   <= ST_RESP;
                  end else begin
                     tbl_ppn_q <= s2_resp_ppn;
                     state_q   <= ST_PMP;
                  end
               end
            end
            ST_PMP: begin
               af_q    <= pmp_fault;
               state_q <= ST_MEM_REQ;
            end
            ST_MEM_REQ: begin
               if (af_q) state_q <= ST_CHECK;
               else if (mem_req_ready) state_q <= ST_MEM_WAIT;
            end
            ST_MEM_WAIT: begin
               if (mem_resp_valid) begin
                  pte_q    <= mem_resp_data;
                  refill_q <= 1'b1;
                  state_q  <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (af_q) begin
                  state_q <= ST_RESP;
               end else if (dec_fault) begin
                  pf_q    <= 1'b1;
                  state_q <= ST_RESP;
               end else if (dec_leaf) begin
                  if (mode_q == XL_ALL) begin
                     gppn_q     <= dec_ppn;
                     final_s2_q <= 1'b1;
                     state_q    <= ST_S2_REQ;
                  end else begin
                     res_ppn_q <= dec_ppn;
                     state_q   <= ST_RESP;
                  end
               end else if (lvl_q > LAST_LVL) begin
                  lvl_q <= lvl_q - LVL_W'(1);
                  if (mode_q == XL_ALL) begin
                     gppn_q  <= dec_ppn;
                     state_q <= ST_S2_REQ;
                  end else begin
                     tbl_ppn_q <= dec_ppn;
                     state_q   <= ST_PMP;
                  end
               end else begin
                  res_ppn_q <= dec_ppn;
                  state_q   <= ST_HANDOFF;
               end
            end
            ST_RESP: begin
               if (resp_ready) state_q <= ST_IDLE;
            end
            ST_HANDOFF: begin
               if (ll_ready) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign pmp_req        = (state_q == ST_PMP);
   assign pmp_addr       = ent_addr;
   assign mem_req_valid  = (state_q == ST_MEM_REQ) && !af_q;
   assign mem_req_addr   = ent_addr;
   assign mem_resp_ready = (state_q == ST_MEM_WAIT);
   assign s2_req_valid   = (state_q == ST_S2_REQ);
   assign s2_req_gppn    = gppn_q;
   assign s2_resp_ready  = (state_q == ST_S2_WAIT);

   assign refill_valid   = refill_q;
   assign refill_vpn     = vpn_q;
   assign refill_level   = lvl_q;
   assign refill_s1      = (mode_q != XL_NONE);
   assign refill_pte     = pte_q;

   assign resp_valid     = (state_q == ST_RESP);
   assign resp_level     = lvl_q;
   assign resp_ppn       = res_ppn_q;
   assign resp_pte       = pte_q;
   assign resp_pf        = pf_q;
   assign resp_af        = af_q;
   assign resp_gpf       = gpf_q;

   assign ll_valid       = (state_q == ST_HANDOFF);
   assign ll_vpn         = vpn_q;
   assign ll_ppn         = res_ppn_q;
   assign ll_mode        = mode_q;

endmodule

// File: rtl/pt2_walker_chk.sv
module pt2_walker_chk #(
   parameter int unsigned PPN_W = 44,
   parameter int unsigned PA_W  = 56,
   parameter int unsigned VPN_W = 27
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             pmp_req,
   input logic [PA_W-1:0]  pmp_addr,
   input logic             pmp_fault,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             mem_resp_valid,
   input logic             mem_resp_ready,
   input logic             s2_req_valid,
   input logic             s2_req_ready,
   input logic [PPN_W-1:0] s2_req_gppn,
   input logic             refill_valid,
   input logic             resp_valid,
   input logic             resp_ready,
   input logic [PPN_W-1:0] resp_ppn,
   input logic             ll_valid,
   input logic             ll_ready,
   input logic [PPN_W-1:0] ll_ppn,
   input logic [VPN_W-1:0] ll_vpn
);

   // R1
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R1
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(mem_req_valid || resp_valid || ll_valid || s2_req_valid));

   // R2
   read_addr_checked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> ($past(pmp_req) && mem_req_addr == $past(pmp_addr)));

   // R3
   fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pmp_req && pmp_fault) |=> !mem_req_valid);

   // R11
   refill_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refill_valid |-> $past(mem_resp_valid && mem_resp_ready));

   // R12
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R12
   s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_req_valid && !s2_req_ready) |=> (s2_req_valid && $stable(s2_req_gppn)));

   // R12
   resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_ppn)));

   // R12
   ll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_valid && !ll_ready) |=> (ll_valid && $stable(ll_ppn) && $stable(ll_vpn)));

   // R1
   single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req_valid, s2_req_valid, resp_valid, ll_valid}));

endmodule

bind pt2_walker pt2_walker_chk #(
   .PPN_W (PPN_W),
   .PA_W  (PA_W),
   .VPN_W (VPN_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .pmp_req        (pmp_req),
   .pmp_addr       (pmp_addr),
   .pmp_fault      (pmp_fault),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_addr   (mem_req_addr),
   .mem_resp_valid (mem_resp_valid),
   .mem_resp_ready (mem_resp_ready),
   .s2_req_valid   (s2_req_valid),
   .s2_req_ready   (s2_req_ready),
   .s2_req_gppn    (s2_req_gppn),
   .refill_valid   (refill_valid),
   .resp_valid     (resp_valid),
   .resp_ready     (resp_ready),
   .resp_ppn       (resp_ppn),
   .ll_valid       (ll_valid),
   .ll_ready       (ll_ready),
   .ll_ppn         (ll_ppn),
   .ll_vpn         (ll_vpn)
);

// File: tb/sim_pt2_walker.sv
`timescale 1ns/1ps
module sim_pt2_walker;

   localparam int PPN_W = 44;
   localparam int VPN_W = 27;
   localparam int PA_W  = 56;
   localparam logic [PPN_W-1:0] S2_KEY = 44'h0A5_5A5A_5A5A;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [1:0]       req_mode = '0;
   logic             req_s1_hit = 1'b0;
   logic [VPN_W-1:0] req_vpn = '0;
   logic [PPN_W-1:0] req_ppn = '0;
   logic             pmp_req;
   logic [PA_W-1:0]  pmp_addr;
   logic             pmp_fault;
   logic             mem_req_valid;
   logic             mem_req_ready = 1'b0;
   logic [PA_W-1:0]  mem_req_addr;
   logic             mem_resp_valid = 1'b0;
   logic             mem_resp_ready;
   logic [63:0]      mem_resp_data = '0;
   logic             s2_req_valid;
   logic             s2_req_ready = 1'b0;
   logic [PPN_W-1:0] s2_req_gppn;
   logic             s2_resp_valid = 1'b0;
   logic             s2_resp_ready;
   logic [PPN_W-1:0] s2_resp_ppn = '0;
   logic             s2_resp_fault = 1'b0;
   logic             refill_valid;
   logic [VPN_W-1:0] refill_vpn;
   logic [1:0]       refill_level;
   logic             refill_s1;
   logic [63:0]      refill_pte;
   logic             resp_valid;
   logic             resp_ready = 1'b0;
   logic [1:0]       resp_level;
   logic [PPN_W-1:0] resp_ppn;
   logic [63:0]      resp_pte;
   logic             resp_pf;
   logic             resp_af;
   logic             resp_gpf;
   logic             ll_valid;
   logic             ll_ready = 1'b0;
   logic [VPN_W-1:0] ll_vpn;
   logic [PPN_W-1:0] ll_ppn;
   logic [1:0]       ll_mode;

   logic             af_en = 1'b0;
   logic [PA_W-1:0]  bad_addr = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   assign pmp_fault = pmp_req && af_en && (pmp_addr == bad_addr);

   pt2_walker u0 (.*);

   function automatic logic [PPN_W-1:0] s2map(input logic [PPN_W-1:0] g);
      return g ^ S2_KEY;
   endfunction

   function automatic logic [63:0] mk_pte(input logic [PPN_W-1:0] p, input logic [7:0] fl);
      return {10'b0, p, 2'b00, fl};
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One walk; term selects the outcome:
   // 0 leaf L2, 1 leaf L1, 2 handoff, 3 V clear L2, 4 W-only L1,
   // 5 access fault L2, 6 access fault L1, 7 guest fault, 8 reserved bit L2
   task automatic do_walk(input logic [1:0] mode, input logic hit, input int term,
                          input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] root);
      logic [PPN_W-1:0] n1, p2, p1, n0;
      logic [PA_W-1:0]  a2, a1;
      logic [63:0]      pte2, pte1;
      logic [PPN_W-1:0] exp_g [4];
      logic [PA_W-1:0]  exp_a [2];
      logic [63:0]      exp_pte [2];
      int n_exp_g, n_exp_rd;
      int n_g, n_rd, n_rf;
      logic s2only, s2all, done, busy_ok, stalled, s2_pend, rd_pend;
      logic [PA_W-1:0]  saved_addr;
      logic [PPN_W-1:0] pend_g;
      logic [PPN_W-1:0] leaf_ppn;
      s2only = (mode == 2'b10) || (mode == 2'b11 && hit);
      s2all  = (mode == 2'b11) && !hit;
      n1 = root + 44'h111;
      p2 = root + 44'h222;
      p1 = root + 44'h333;
      n0 = root + 44'h444;
      a2 = {s2all ? s2map(root) : root, vpn[26:18], 3'b000};
      a1 = {s2all ? s2map(n1) : n1, vpn[17:9], 3'b000};
      case (term)
         0: pte2 = mk_pte(p2, 8'h0B);
         3: pte2 = mk_pte(n1, 8'h00);
         8: pte2 = mk_pte(n1, 8'h01) | (64'd1 << 60);
         default: pte2 = mk_pte(n1, 8'h01);
      endcase
      case (term)
         1: pte1 = mk_pte(p1, 8'h0B);
         4: pte1 = mk_pte(p1, 8'h05);
         default: pte1 = mk_pte(n0, 8'h01);
      endcase
      exp_a[0] = a2; exp_a[1] = a1;
      exp_pte[0] = pte2; exp_pte[1] = pte1;
      if (s2only) n_exp_rd = 0;
      else if (term == 5 || term == 7) n_exp_rd = 0;
      else if (term == 0 || term == 3 || term == 8 || term == 6) n_exp_rd = 1;
      else n_exp_rd = 2;
      exp_g[0] = root; exp_g[1] = '0; exp_g[2] = '0; exp_g[3] = '0;
      n_exp_g = 0;
      if (s2only) n_exp_g = 1;
      else if (s2all) begin
         n_exp_g = 1;
         if (term == 0) begin exp_g[1] = p2; n_exp_g = 2; end
         if (term == 1 || term == 2 || term == 4 || term == 6) begin exp_g[1] = n1; n_exp_g = 2; end
         if (term == 1) begin exp_g[2] = p1; n_exp_g = 3; end
      end
      af_en = (term == 5 || term == 6);
      bad_addr = (term == 5) ? a2 : a1;

      @(negedge clk);
      // R1: idle before the request
      chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_mode = mode; req_s1_hit = hit; req_vpn = vpn; req_ppn = root;
      done = 1'b0; busy_ok = 1'b1; stalled = 1'b0; s2_pend = 1'b0; rd_pend = 1'b0;
      n_g = 0; n_rd = 0; n_rf = 0; saved_addr = '0; pend_g = '0;
      for (int cyc = 0; cyc < 300 && !done; cyc++) begin
         @(negedge clk);
         req_valid = 1'b0; mem_req_ready = 1'b0; s2_req_ready = 1'b0;
         mem_resp_valid = 1'b0; s2_resp_valid = 1'b0;
         if (req_ready) busy_ok = 1'b0;
         if (refill_valid) begin
            // R11
            chk(refill_vpn == vpn && refill_level == ((n_rf == 0) ? 2'd2 : 2'd1)
                && refill_s1 == (mode != 2'b00) && n_rf < 2 && refill_pte == exp_pte[n_rf & 1],
                "R11 refill record", {refill_pte[31:0], 21'b0, refill_s1, refill_level, 8'b0},
                {exp_pte[n_rf & 1][31:0], 21'b0, (mode != 2'b00), (n_rf == 0) ? 2'd2 : 2'd1, 8'b0});
            n_rf++;
         end
         if (rd_pend) begin
            mem_resp_valid = 1'b1;
            mem_resp_data = exp_pte[(n_rd - 1) & 1];
            rd_pend = 1'b0;
         end else if (s2_pend) begin
            s2_resp_valid = 1'b1;
            s2_resp_ppn = s2map(pend_g);
            s2_resp_fault = (term == 7);
            s2_pend = 1'b0;
         end else if (mem_req_valid) begin
            if (!stalled) begin
               stalled = 1'b1;
               saved_addr = mem_req_addr;
            end else begin
               // R12 hold, R2 / R4 / R8 address
               chk(mem_req_addr == saved_addr, "R12 read address held", 64'(mem_req_addr), 64'(saved_addr));
               chk(n_rd < n_exp_rd && mem_req_addr == exp_a[n_rd & 1], "R2 R4 R8 read address",
                   64'(mem_req_addr), 64'(exp_a[n_rd & 1]));
               mem_req_ready = 1'b1;
               n_rd++;
               stalled = 1'b0;
               rd_pend = 1'b1;
            end
         end else if (s2_req_valid) begin
            // R7 R8 R9
            chk(n_g < n_exp_g && s2_req_gppn == exp_g[n_g & 3], "R7 R8 R9 second-stage page",
                64'(s2_req_gppn), 64'(exp_g[n_g & 3]));
            s2_req_ready = 1'b1;
            pend_g = s2_req_gppn;
            n_g++;
            s2_pend = 1'b1;
         end else if (resp_valid) begin
            resp_ready = 1'b1;
            done = 1'b1;
            chk(!(term == 2 && !s2only), "R4 expected handoff, got response", 64'd1, 64'd0);
            if (term == 7) begin
               // R10
               chk(resp_gpf && !resp_pf && !resp_af, "R10 guest fault flag",
                   64'({resp_gpf, resp_pf, resp_af}), 64'b100);
            end else if (s2only) begin
               // R7 R9
               chk(resp_ppn == s2map(root) && resp_level == 2'd0 && !resp_pf && !resp_af && !resp_gpf,
                   "R7 R9 translated page", {18'b0, resp_level, resp_ppn}, {20'b0, s2map(root)});
            end else if (term == 5 || term == 6) begin
               // R3
               chk(resp_af && !resp_pf && resp_level == ((term == 5) ? 2'd2 : 2'd1),
                   "R3 access fault level", 64'({resp_af, resp_pf, resp_level}),
                   64'({2'b10, (term == 5) ? 2'd2 : 2'd1}));
            end else if (term == 3 || term == 4 || term == 8) begin
               // R6 R13
               chk(resp_pf && !resp_af && resp_level == ((term == 4) ? 2'd1 : 2'd2),
                   "R6 R13 page fault level", 64'({resp_pf, resp_af, resp_level}),
                   64'({2'b10, (term == 4) ? 2'd1 : 2'd2}));
            end else begin
               // R5 R8
               leaf_ppn = (term == 0) ? p2 : p1;
               if (s2all) leaf_ppn = s2map(leaf_ppn);
               chk(resp_ppn == leaf_ppn && !resp_pf && !resp_af && !resp_gpf,
                   "R5 R8 leaf page", 64'(resp_ppn), 64'(leaf_ppn));
               chk(resp_level == ((term == 0) ? 2'd2 : 2'd1) && resp_pte == ((term == 0) ? pte2 : pte1),
                   "R5 leaf level and entry", resp_pte, (term == 0) ? pte2 : pte1);
            end
         end else if (ll_valid) begin
            ll_ready = 1'b1;
            done = 1'b1;
            // R4
            chk(term == 2 && ll_vpn == vpn && ll_ppn == n0 && ll_mode == mode,
                "R4 handoff payload", 64'(ll_ppn), 64'(n0));
         end
      end
      @(negedge clk);
      resp_ready = 1'b0; ll_ready = 1'b0; mem_req_ready = 1'b0; s2_req_ready = 1'b0;
      mem_resp_valid = 1'b0; s2_resp_valid = 1'b0;
      chk(done, "R1 walk completed", 64'(done), 64'd1);
      chk(busy_ok, "R1 ready low while busy", 64'(busy_ok), 64'd1);
      // R3 R10 no reads on fault paths; R11 one refill per read
      chk(n_rd == n_exp_rd && n_rf == n_exp_rd, "R3 R10 R11 read and refill count",
          64'({n_rd[15:0], n_rf[15:0]}), 64'({n_exp_rd[15:0], n_exp_rd[15:0]}));
      chk(n_g == n_exp_g, "R7 R8 R9 second-stage request count", 64'(n_g), 64'(n_exp_g));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !mem_req_valid && !resp_valid && !ll_valid && !s2_req_valid && !refill_valid,
          "R1 reset outputs", 64'({req_ready, mem_req_valid, resp_valid, ll_valid, s2_req_valid, refill_valid}),
          64'b100000);
      for (int vv = 0; vv < 2; vv++) begin
         for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 2; h++) begin
               for (int t = 0; t < 9; t++) begin
                  if (h == 1 && m != 3) continue;
                  if ((m == 2 || (m == 3 && h == 1)) && !(t == 0 || t == 7)) continue;
                  if (m < 2 && t == 7) continue;
                  do_walk(2'(m), h[0], t,
                          (vv == 0) ? 27'h7FF_FFFF : 27'h52A_3B1C,
                          (vv == 0) ? 44'hFFF_FFFF_F000 : 44'h000_0001_2340);
               end
            end
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule